// File: doc/BRIEF.md
# Clock Period Meter

The block measures the period of a clock of unknown, unrelated frequency against a fixed 125 MHz reference (8 ns per cycle). Inside its own domain, the clock under test drives a free-running 7-bit divider. The divider's top bit is brought into the reference domain through a two-flop synchroniser. Its rising edge then marks one interval of exactly 128 input cycles. Across that interval the reference domain counts its own cycles.

Because 128 input cycles × 1/8 ns equals 16 × the input period in ns, the count is the input period in units of 1/16 ns. No arithmetic is needed to get it.

The result is a 16-bit word. The low 15 bits carry the last stored period. The top bit is a mismatch flag, raised when the period rounded to whole nanoseconds differs from the `EXP_VALUE` parameter. The flag is also raised while no valid measurement exists yet.

Top module: `clk_period_meter`

## Requirements
- R1: While reset is asserted and after it until the first valid measurement, `period_o` reads 16'h8000 (period field 0, flag 1).
- R2: A valid measurement in `period_o[14:0]` equals the number of reference cycles spanned by 128 input cycles, that is 16 × the input period in ns, within ±1 LSB.
- R3: The stored period changes only when a rising edge of the synchronised divider top bit arrives; with the input clock stopped, `period_o` holds its last value.
- R4: The first interval after reset is partial and is discarded; `period_o` stays at 16'h8000 until a second divider edge has been seen.
- R5: The running count saturates at 15'h7FFF and never wraps. An interval longer than 32767 reference cycles is reported as 15'h7FFF, with bit 15 set.
- R6: `period_o[15]` is 1 when the rounded period `period_o[14:4] + period_o[3]` (12-bit sum) differs from `EXP_VALUE`, and 0 when it matches.
- R7: After a saturated interval, the next full interval is measured correctly again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk_i | input | 1 | 125 MHz reference clock |
| meas_clk_i | input | 1 | Clock under test, asynchronous to the reference |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| period_o | output | 16 | Bit 15: mismatch or no-valid flag; bits 14:0: period in 1/16 ns |

## Verification
A corrupted running count shows at the port one interval later, as a period off by more than one LSB or stuck at the saturation value. A broken edge detector or discard flag shows within the first two divider periods after reset, as an early or doubled update of the output word. A wrong rounding or compare flips bit 15 as soon as the first valid period is stored. Input periods on both sides of a rounding boundary expose that. A stopped input held beyond the counter range shows a wrap as a small value after restart instead of 15'h7FFF.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  localparam int DIV_W  = 7;   // 2**DIV_W input cycles per interval
  localparam int CNT_W  = 15;  // period field width
  localparam int SYNC_N = 2;   // synchroniser depth
  localparam int FRAC_W = 4;   // fractional bits: 1/16 ns
  localparam int RND_W  = CNT_W - FRAC_W + 1;
endpackage

// File: rtl/cpm_divider.sv
module cpm_divider #(
  parameter int W = cpm_pkg::DIV_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tap_o
);
  logic [W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  assign tap_o = div_q[W-1];
endmodule

// File: rtl/cpm_sync_edge.sv
module cpm_sync_edge #(
  parameter int N = cpm_pkg::SYNC_N
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [N-1:0] sync_q;
  logic         prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[N-2:0], d_i};
      prev_q <= sync_q[N-1];
    end
  end

  assign rise_o = sync_q[N-1] & ~prev_q;

  // a rising edge yields a single-cycle pulse
  assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/cpm_period_counter.sv
module cpm_period_counter #(
  parameter int W = cpm_pkg::CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pulse_i,
  output logic [W-1:0] period_o,
  output logic         valid_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q, period_q;
  logic         armed_q, valid_q;
  logic [W-1:0] cnt_inc;

  assign cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      period_q <= '0;
      armed_q  <= 1'b0;
      valid_q  <= 1'b0;
    end else if (pulse_i) begin
      cnt_q   <= {{(W-1){1'b0}}, 1'b1};
      armed_q <= 1'b1;
      if (armed_q) begin   // first interval after reset is partial
        period_q <= cnt_q;
        valid_q  <= 1'b1;
      end
    end else begin
      cnt_q <= cnt_inc;
    end
  end

  assign period_o = period_q;
  assign valid_o  = valid_q;

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_no_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_i |=> $stable(period_q) && $stable(valid_q));
  assert_discard_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && !armed_q) |=> !valid_q);
endmodule

// File: rtl/cpm_mismatch.sv
module cpm_mismatch #(
  parameter int W         = cpm_pkg::CNT_W,
  parameter int EXP_VALUE = 8
) (
  input  logic [W-1:0] period_i,
  input  logic         valid_i,
  output logic         flag_o
);
  localparam int FW = cpm_pkg::FRAC_W;
  localparam int RW = W - FW + 1;

  logic [RW-1:0] rounded;

  always_comb begin
    rounded = {1'b0, period_i[W-1:FW]} + RW'(period_i[FW-1]);
    flag_o  = !valid_i || (rounded != RW'(EXP_VALUE));
  end
endmodule

// File: rtl/clk_period_meter.sv
module clk_period_meter #(
  parameter int DIV_W     = cpm_pkg::DIV_W,
  parameter int CNT_W     = cpm_pkg::CNT_W,
  parameter int SYNC_N    = cpm_pkg::SYNC_N,
  parameter int EXP_VALUE = 8
) (
  input  logic             ref_clk_i,
  input  logic             meas_clk_i,
  input  logic             rst_ni,
  output logic [CNT_W:0]   period_o
);
  logic             tap;
  logic             pulse;
  logic [CNT_W-1:0] period;
  logic             valid;
  logic             flag;

  cpm_divider #(.W(DIV_W)) u_div (
    .clk_i (meas_clk_i),
    .rst_ni(rst_ni),
    .tap_o (tap)
  );

  cpm_sync_edge #(.N(SYNC_N)) u_sync (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .d_i   (tap),
    .rise_o(pulse)
  );

  cpm_period_counter #(.W(CNT_W)) u_cnt (
    .clk_i   (ref_clk_i),
    .rst_ni  (rst_ni),
    .pulse_i (pulse),
    .period_o(period),
    .valid_o (valid)
  );

  cpm_mismatch #(.W(CNT_W), .EXP_VALUE(EXP_VALUE)) u_cmp (
    .period_i(period),
    .valid_i (valid),
    .flag_o  (flag)
  );

  assign period_o = {flag, period};

  assert_no_valid_flag_R1: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !valid |-> (period_o[CNT_W] && period_o[CNT_W-1:0] == '0));
  assert_valid_needs_pulse_R4: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $rose(valid) |-> $past(pulse));
endmodule

// File: tb/sim_clk_period_meter.sv
`timescale 1ns/1ps
module sim_clk_period_meter;
  localparam int EXP = 8;
  localparam int NV  = 6;
  // input period (ps), ideal count, expected flag with EXP = 8
  localparam int VEC_PS  [NV] = '{8000, 10000, 40000, 5000, 8400, 7600};
  localparam int VEC_CNT [NV] = '{128,  160,   640,   80,   134,  122};
  localparam bit VEC_FLAG[NV] = '{1'b0, 1'b1,  1'b1,  1'b1, 1'b0, 1'b0};

  logic        ref_clk = 1'b0;
  logic        meas_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] period;
  bit          meas_run = 1'b1;
  real         meas_half = 5.0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  clk_period_meter #(.EXP_VALUE(EXP)) u0 (
    .ref_clk_i (ref_clk),
    .meas_clk_i(meas_clk),
    .rst_ni    (rst_n),
    .period_o  (period)
  );

  always #4 ref_clk = ~ref_clk;

  always begin
    if (meas_run) #(meas_half) meas_clk = ~meas_clk;
    else          #1;
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%04h) expected %0d (0x%04h)", req, act, act, exp, exp);
    end
  endtask

  task automatic chk_period(input string req, input int exp_cnt, input bit exp_flag);
    int d;
    d = int'(period[14:0]) - exp_cnt;
    chk({req, " period"}, d >= -1 && d <= 1, int'(period[14:0]), exp_cnt);
    chk({req, " flag R6"}, period[15] == exp_flag, int'(period[15]), int'(exp_flag));
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int held;
    bit seen_sat;
    // R1: reset value
    wait_ref(5);
    chk("R1 reset word", period == 16'h8000, int'(period), 32'h8000);
    rst_n = 1'b1;
    // R4: first edge near 640 ns, second near 1920 ns for a 10 ns input
    #1500;
    @(negedge ref_clk);
    chk("R4 partial interval discarded", period == 16'h8000, int'(period), 32'h8000);
    #1100;
    @(negedge ref_clk);
    chk_period("R2 first valid 10ns", 160, 1'b1);

    // R2/R6: vector table
    for (int i = 0; i < NV; i++) begin
      meas_half = VEC_PS[i] / 2000.0;
      #(3.0 * 128.0 * VEC_PS[i] / 1000.0 + 100.0);
      @(negedge ref_clk);
      chk_period($sformatf("R2 vec%0d %0dps", i, VEC_PS[i]), VEC_CNT[i], VEC_FLAG[i]);
    end

    // R3: stopped input holds last value
    meas_half = 4.0;
    #(3 * 128 * 8 + 100);
    @(negedge ref_clk);
    held = int'(period);
    meas_run = 1'b0;
    wait_ref(1000);
    chk("R3 hold with stopped input", int'(period) == held, int'(period), held);
    chk_period("R7 reference 8ns before stop", 128, 1'b0);

    // R5: stop beyond counter range, then restart
    wait_ref(33500);
    chk("R3 hold after long stop", int'(period) == held, int'(period), held);
    meas_run = 1'b1;
    seen_sat = 1'b0;
    for (int k = 0; k < 200 && !seen_sat; k++) begin
      @(negedge ref_clk);
      if (period == 16'hFFFF) seen_sat = 1'b1;
    end
    chk("R5 saturated word 0xFFFF", seen_sat, int'(period), 32'hFFFF);

    // R7: recovery after saturation
    #(3 * 128 * 8 + 100);
    @(negedge ref_clk);
    chk_period("R7 recovery 8ns", 128, 1'b0);

    // R1: reset mid-run returns to no-valid word
    @(negedge ref_clk);
    rst_n = 1'b0;
    wait_ref(2);
    chk("R1 reset mid-run", period == 16'h8000, int'(period), 32'h8000);
    rst_n = 1'b1;
    wait_ref(10);
    chk("R4 no early valid after reset", period == 16'h8000, int'(period), 32'h8000);

    done = 1'b1;
    summary();
  end
endmodule